// File: doc/BRIEF.md
# Matrix Multiply Index Schedule Generator

This block is a loop-nest sequencer that drives an in-place matrix multiply C += A × B, one scalar multiply-accumulate per step. Software loads three dimensions: M is the number of rows of A, K is the shared inner dimension, and N is the number of columns of B. It also loads a reverse flag for each dimension and a loop-order select. After a start pulse the block steps through every (i, v, j) triple exactly once. For each triple it presents three register offsets: one for the accumulator element of C and one each for the elements of A and B. A downstream issue stage takes one step for every cycle in which both valid and ready are high.

The default order puts i in the outer loop, v in the middle loop and j in the inner loop. With this order, back-to-back steps write different accumulator elements, so there is no read-after-write chain on the accumulator. Any of the six nesting orders can be chosen instead, and any dimension can run downward. Dimensions do not have to be powers of two. The whole schedule is limited to 127 steps.

Top module: `mm_index_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, step_valid, done and err are all 0.
- R2: A start pulse with a legal configuration, given while idle, makes step_valid high after the next clock edge. Matrices are stored row-major, so the offsets are ofs_c = i*N + j, ofs_a = i*K + v and ofs_b = v*N + j.
- R3: cfg_order selects the nesting as (outer, middle, inner): 0 = (i,v,j), 1 = (i,j,v), 2 = (v,i,j), 3 = (v,j,i), 4 = (j,i,v), 5 = (j,v,i). The inner loop advances on every accepted step. Each outer loop advances when every loop inside it wraps.
- R4: A run produces exactly M*K*N accepted steps and visits every triple once. This holds for any size from 1 to 127, not only powers of two.
- R5: cfg_rev bit 0 reverses i, bit 1 reverses v and bit 2 reverses j. A reversed dimension counts down from dim-1 to 0, and every wrap reloads its start value (0, or dim-1 when reversed).
- R6: done is high in exactly the cycle that presents the final step. After that step is accepted, step_valid goes low and the block stays idle until the next start.
- R7: A configuration with any dimension equal to 0, with M*K*N above 127, or with cfg_order above 5 produces no steps. err goes high after the next edge and stays high until the next start. A legal start clears it.
- R8: While step_valid is high and step_ready is low, the step and its three offsets are held unchanged.
- R9: A start pulse during a run is ignored. The schedule already in progress continues without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and begin a schedule when idle |
| cfg_m | input | 7 | Rows of A (M) |
| cfg_k | input | 7 | Shared inner dimension (K) |
| cfg_n | input | 7 | Columns of B (N) |
| cfg_rev | input | 3 | Reverse flags: bit0 i, bit1 v, bit2 j |
| cfg_order | input | 3 | Loop nesting select, 0..5 |
| step_ready | input | 1 | Consumer accepts the current step |
| step_valid | output | 1 | A step is presented |
| ofs_c | output | 7 | Accumulator (C) element offset |
| ofs_a | output | 7 | A element offset |
| ofs_b | output | 7 | B element offset |
| done | output | 1 | Current step is the final one |
| err | output | 1 | Last start was rejected |

## Verification
Two events can fall in the same cycle: a stall, which holds the step, and wraps in several loops at once, which can carry all three counters at the same edge. The bench drives a ready pattern that drops one cycle in three. Over a full sweep of small shapes, all nestings and all reverse masks, this pattern lands stalls on steps where the inner and middle loops both wrap. Each presented step is compared with a triple the bench decomposes from the step index, and a stalled step must present the same offsets again. A second overlap is a start pulse that arrives mid-run, next to a handshake. It is judged by the run's offsets and step count staying as expected.

// File: rtl/mm_idx_pkg.sv
package mm_idx_pkg;
  localparam int DIM_W     = 7;
  localparam int OFS_W     = 7;
  localparam int ORD_W     = 3;
  localparam int MAX_STEPS = 127;
  localparam int N_ORDERS  = 6;

  // dimension selectors: i = A row, v = shared, j = B column
  typedef logic [1:0] dsel_t;
  localparam dsel_t D_I = 2'd0;
  localparam dsel_t D_V = 2'd1;
  localparam dsel_t D_J = 2'd2;

  typedef struct packed {
    dsel_t outer;
    dsel_t mid;
    dsel_t inner;
  } nest_t;

  typedef enum logic {ST_IDLE, ST_RUN} gen_state_t;

  function automatic nest_t decode_order(input logic [ORD_W-1:0] sel);
    nest_t r;
    case (sel)
      3'd1:    r = '{outer: D_I, mid: D_J, inner: D_V};
      3'd2:    r = '{outer: D_V, mid: D_I, inner: D_J};
      3'd3:    r = '{outer: D_V, mid: D_J, inner: D_I};
      3'd4:    r = '{outer: D_J, mid: D_I, inner: D_V};
      3'd5:    r = '{outer: D_J, mid: D_V, inner: D_I};
      default: r = '{outer: D_I, mid: D_V, inner: D_J};
    endcase
    return r;
  endfunction

  // row-major linear offset: row * stride + col
  function automatic int lin_ofs(input int row, input int stride, input int col);
    return row * stride + col;
  endfunction
endpackage

// File: rtl/mm_cfg_check.sv
module mm_cfg_check
  import mm_idx_pkg::*;
#(
  parameter int W   = DIM_W,
  parameter int LIM = MAX_STEPS
) (
  input  logic [W-1:0]     dim_m,
  input  logic [W-1:0]     dim_k,
  input  logic [W-1:0]     dim_n,
  input  logic [ORD_W-1:0] order,
  output logic             cfg_ok
);
  localparam int PW = 3 * W;
  logic [PW-1:0] prod;
  logic          nonzero;
  logic          fits;
  logic          ord_legal;

  always_comb begin
    prod      = PW'(dim_m) * PW'(dim_k) * PW'(dim_n);
    nonzero   = (dim_m != '0) && (dim_k != '0) && (dim_n != '0);
    fits      = prod <= PW'(LIM);
    ord_legal = int'(order) < N_ORDERS;
    cfg_ok    = nonzero && fits && ord_legal;
  end
endmodule

// File: rtl/mm_loop_ctr.sv
module mm_loop_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dim_in,
  input  logic         rev_in,
  input  logic         adv,
  input  logic         active,
  output logic [W-1:0] val,
  output logic [W-1:0] dim_q,
  output logic         at_end
);
  logic         rev_q;
  logic [W-1:0] load_v;
  logic [W-1:0] wrap_v;

  assign load_v = rev_in ? dim_in - W'(1) : '0;
  assign wrap_v = rev_q  ? dim_q  - W'(1) : '0;
  assign at_end = rev_q ? (val == '0) : (val == dim_q - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val   <= '0;
      dim_q <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      val   <= load_v;
      dim_q <= dim_in;
      rev_q <= rev_in;
    end else if (adv) begin
      if (at_end)     val <= wrap_v;
      else if (rev_q) val <= val - W'(1);
      else            val <= val + W'(1);
    end
  end

  AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> val < dim_q);  // R4
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_end && !load) |=> val == $past(wrap_v));  // R5
endmodule

// File: rtl/mm_index_gen.sv
module mm_index_gen
  import mm_idx_pkg::*;
#(
  parameter int DW  = DIM_W,
  parameter int OW  = OFS_W,
  parameter int LIM = MAX_STEPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    cfg_m,
  input  logic [DW-1:0]    cfg_k,
  input  logic [DW-1:0]    cfg_n,
  input  logic [2:0]       cfg_rev,
  input  logic [ORD_W-1:0] cfg_order,
  input  logic             step_ready,
  output logic             step_valid,
  output logic [OW-1:0]    ofs_c,
  output logic [OW-1:0]    ofs_a,
  output logic [OW-1:0]    ofs_b,
  output logic             done,
  output logic             err
);
  gen_state_t    st;
  nest_t         nest_q;
  logic          cfg_ok;
  logic          accept;
  logic          load;
  logic          fire;
  logic          last;
  logic          wrap_inner;
  logic          wrap_mid;
  logic [DW-1:0] cfg_dim [3];
  logic [DW-1:0] cnt     [3];
  logic [DW-1:0] dlen    [3];
  logic [2:0]    at_end;
  logic [2:0]    adv;

  mm_cfg_check #(.W(DW), .LIM(LIM)) u_chk (
    .dim_m (cfg_m),
    .dim_k (cfg_k),
    .dim_n (cfg_n),
    .order (cfg_order),
    .cfg_ok(cfg_ok)
  );

  assign cfg_dim[0] = cfg_m;
  assign cfg_dim[1] = cfg_k;
  assign cfg_dim[2] = cfg_n;

  assign accept     = (st == ST_IDLE) && start;
  assign load       = accept && cfg_ok;
  assign step_valid = (st == ST_RUN);
  assign fire       = step_valid && step_ready;
  assign wrap_inner = at_end[nest_q.inner];
  assign wrap_mid   = at_end[nest_q.mid];
  assign last       = &at_end;
  assign done       = step_valid && last;

  for (genvar g = 0; g < 3; g++) begin : g_dim
    assign adv[g] = fire && ((nest_q.inner == dsel_t'(g)) ? 1'b1 :
                             (nest_q.mid   == dsel_t'(g)) ? wrap_inner :
                                                            (wrap_inner && wrap_mid));
    mm_loop_ctr #(.W(DW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .dim_in(cfg_dim[g]),
      .rev_in(cfg_rev[g]),
      .adv   (adv[g]),
      .active(step_valid),
      .val   (cnt[g]),
      .dim_q (dlen[g]),
      .at_end(at_end[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err    <= 1'b0;
      nest_q <= decode_order('0);
    end else if (accept) begin
      err    <= !cfg_ok;
      nest_q <= decode_order(cfg_order);
      if (cfg_ok) st <= ST_RUN;
    end else if (fire && last) begin
      st <= ST_IDLE;
    end
  end

  int c_lin, a_lin, b_lin;
  always_comb begin
    c_lin = lin_ofs(int'(cnt[0]), int'(dlen[2]), int'(cnt[2]));
    a_lin = lin_ofs(int'(cnt[0]), int'(dlen[1]), int'(cnt[1]));
    b_lin = lin_ofs(int'(cnt[1]), int'(dlen[2]), int'(cnt[2]));
    ofs_c = c_lin[OW-1:0];
    ofs_a = a_lin[OW-1:0];
    ofs_b = b_lin[OW-1:0];
  end

  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> step_valid);  // R6
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step_ready) |=> !step_valid);  // R6
  AST_ERR_NO_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !step_valid);  // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_ready) |=> step_valid && $stable(ofs_c) && $stable(ofs_a) && $stable(ofs_b));  // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && start && !done) |=> step_valid && !err);  // R9
endmodule

// File: tb/mm_index_gen_test.sv
`timescale 1ns/1ps
module mm_index_gen_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] cfg_m = '0, cfg_k = '0, cfg_n = '0;
  logic [2:0] cfg_rev = '0, cfg_order = '0;
  logic       step_ready = 1'b0;
  logic       step_valid, done, err;
  logic [6:0] ofs_c, ofs_a, ofs_b;

  mm_index_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n),
    .cfg_rev(cfg_rev), .cfg_order(cfg_order), .step_ready(step_ready),
    .step_valid(step_valid), .ofs_c(ofs_c), .ofs_a(ofs_a), .ofs_b(ofs_b),
    .done(done), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // nesting table (outer, mid, inner) per R3: 0=i 1=v 2=j
  function automatic int pos_dim(input int ord, input int pos);
    int t [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    return t[ord][pos];
  endfunction

  task automatic run_cfg(input int m, input int k, input int n,
                         input int ord, input int rev, input bit poke);
    int dsz [3];
    int x   [3];
    int total, s, guard, di, dm, dd;
    string tag;
    bit rdy;
    dsz[0] = m; dsz[1] = k; dsz[2] = n;
    total = m * k * n;
    tag = (rev != 0) ? "R5" : ((ord != 0) ? "R3" : "R2");
    @(negedge clk);
    cfg_m = 7'(m); cfg_k = 7'(k); cfg_n = 7'(n);
    cfg_order = 3'(ord); cfg_rev = 3'(rev); start = 1'b1;
    step_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R7 err cleared by legal start", int'(err), 0);
    s = 0;
    guard = 0;
    while (s < total && guard < 1000) begin
      guard++;
      di = dsz[pos_dim(ord, 2)];
      dm = dsz[pos_dim(ord, 1)];
      x[pos_dim(ord, 2)] = s % di;
      x[pos_dim(ord, 1)] = (s / di) % dm;
      x[pos_dim(ord, 0)] = s / (di * dm);
      for (int d = 0; d < 3; d++)
        if (rev[d]) x[d] = dsz[d] - 1 - x[d];
      chk(step_valid == 1'b1, "R2 step_valid", int'(step_valid), 1);
      chk(int'(ofs_c) == x[0] * n + x[2], {tag, " ofs_c"}, int'(ofs_c), x[0] * n + x[2]);
      chk(int'(ofs_a) == x[0] * k + x[1], {tag, " ofs_a"}, int'(ofs_a), x[0] * k + x[1]);
      chk(int'(ofs_b) == x[1] * n + x[2], {tag, " ofs_b"}, int'(ofs_b), x[1] * n + x[2]);
      dd = (s == total - 1) ? 1 : 0;
      chk(int'(done) == dd, "R6 done on final step", int'(done), dd);
      rdy = (guard % 3) != 1;   // stalls exercise R8 on the next compare
      step_ready = rdy;
      if (poke && s == 1) begin
        start = 1'b1;           // R9: must be ignored
        cfg_m = 7'd0;
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) s++;
    end
    step_ready = 1'b0;
    chk(s == total, "R4 step count", s, total);
    chk(step_valid == 1'b0, "R6 idle after last", int'(step_valid), 0);
    @(negedge clk);
    chk(step_valid == 1'b0 && done == 1'b0, "R6 stays idle", int'(step_valid), 0);
    if (poke) chk(err == 1'b0, "R9 mid-run start ignored", int'(err), 0);
  endtask

  task automatic reject(input int m, input int k, input int n, input int ord);
    @(negedge clk);
    cfg_m = 7'(m); cfg_k = 7'(k); cfg_n = 7'(n);
    cfg_order = 3'(ord); cfg_rev = 3'd0; start = 1'b1;
    step_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R7 err raised", int'(err), 1);
    for (int c = 0; c < 3; c++) begin
      chk(step_valid == 1'b0, "R7 no steps", int'(step_valid), 0);
      chk(err == 1'b1, "R7 err held", int'(err), 1);
      @(negedge clk);
    end
    step_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(step_valid == 1'b0, "R1 valid in reset", int'(step_valid), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(err == 1'b0, "R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_valid == 1'b0 && err == 1'b0, "R1 idle after reset", int'(step_valid), 0);

    for (int m = 1; m <= 3; m++)
      for (int k = 1; k <= 3; k++)
        for (int n = 1; n <= 3; n++)
          for (int o = 0; o < 6; o++)
            for (int r = 0; r < 8; r++)
              run_cfg(m, k, n, o, r, 1'b0);

    run_cfg(7, 6, 3, 0, 5, 1'b1);   // R4 126 steps, non power of two, R9
    run_cfg(127, 1, 1, 3, 7, 1'b0); // R4 limit
    run_cfg(1, 127, 1, 5, 2, 1'b0);
    reject(8, 4, 4, 0);             // R7 product 128
    reject(0, 3, 3, 1);
    reject(3, 3, 0, 2);
    reject(3, 3, 3, 6);
    reject(2, 2, 2, 7);
    run_cfg(5, 5, 5, 4, 6, 1'b1);   // R7 err cleared, R9

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule